// File: doc/BRIEF.md
# Gate Dead-Time Inserter

This block sits between the six raw gate-drive signals of a three-phase bridge and the gate-driver pins. Each phase has a high-side and a low-side switch. If the raw pattern turns one switch of a phase off and the other on in the same cycle, the outgoing switch may still conduct while the incoming one starts. The inserter prevents this by holding back every switch-on edge for a programmable number of count ticks. Switch-off edges pass through at once. The result is a gap in every commutation in which neither switch of the pair conducts.

Each of the six gate lines has its own down-counter. The count length is taken from a shared setting register. A select input picks how often a count tick occurs: every clock, or every second clock. A second select picks what starts a count: the channel's own switch-on edge, or a pulse from an external carrier timer. A global enable allows the delay to be bypassed so that the outputs copy the raw gates.

Top module: `gate_deadtime`

## Requirements
- R1: The active level on every gate line is 1 (switch conducting). After a synchronous reset, with all raw gates at 0, every output is 0. The setting register resets to 1, so a switch-on edge before any load is delayed by one tick.
- R2: A clock edge with `dt_load` high stores `dt_setting` into the setting register. Values 1 to 255 give a delay of that many ticks. A stored value of 0 behaves as 1.
- R3: With dead time enabled, full-rate ticks and edge start, a raw gate that is first seen high at clock edge s drives its output high after edge s+n, where n is the setting. Before that edge the output stays 0.
- R4: A raw gate that goes to 0 drives its output to 0 in the same cycle, with no delay.
- R5: With `src_half` = 1, a tick occurs only on the second, fourth, sixth (and so on) clock edges after reset release. The n ticks of a delay are counted only on those edges, starting after the start edge.
- R6: With `trig_timer` = 0, a count starts on the clock edge where a channel's raw gate is first seen high.
- R7: With `trig_timer` = 1, a channel's raw rising edge alone starts nothing. A count starts on an edge where `tmr_uflow` is 1 while that raw gate is high and the channel is neither active nor counting. The delay then runs as in R3.
- R8: If a raw gate returns to 0 while its count is running, the pending switch-on is cancelled. A later rise needs a complete new count.
- R9: With `dt_enable` = 0, every output equals its raw gate and the setting has no effect. When the enable is set again while a raw gate is high, that output stays high without a new delay.
- R10: The channels count independently. When the raw pattern swaps the two switches of a pair in one cycle, the outgoing output drops at once and the incoming one rises n ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dt_setting | input | 8 | Dead-time tick count to be stored |
| dt_load | input | 1 | Store `dt_setting` on this edge |
| src_half | input | 1 | Tick source: 0 every clock, 1 every second clock |
| trig_timer | input | 1 | Start select: 0 raw rising edge, 1 external timer pulse |
| dt_enable | input | 1 | 1 inserts dead time, 0 bypasses it |
| tmr_uflow | input | 1 | One-cycle underflow pulse from a carrier timer |
| gate_raw | input | 6 | Raw gate signals, two per phase |
| gate_out | output | 6 | Conditioned gate signals |

## Verification
The bench checks that an output rises neither one tick early nor one tick late, for the smallest delay, for the largest delay of 255, and for a stored 0. A counter that loads n-1, or that does not map 0 to 1, misses one of these cycles. Under the halved tick rate, delays are started on both clock parities, so a divider that counts from the start edge instead of running freely is caught. A raw pulse that is dropped and then raised again must not switch on early, which exposes a design that lets a stale count complete. In timer-start mode an output must stay low through a raw rise with no pulse, and the pair-swap and bypass re-enable cases catch designs that delay switch-off edges or lose channel state across bypass.

// File: rtl/gdt_pkg.sv
// Package gdt_pkg
// Shared encodings for the gate dead-time inserter: the tick source select
// and the start trigger select. Assumes one-bit select inputs at the top.
package gdt_pkg;

    typedef enum logic {
        SRC_CLK      = 1'b0,
        SRC_CLK_DIV2 = 1'b1
    } src_sel_e;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_TIMER = 1'b1
    } trig_sel_e;

endpackage

// File: rtl/gdt_tick_gen.sv
// Module gdt_tick_gen
// Produces the count-tick enable shared by all channels. In full-rate mode
// every clock is a tick. In half-rate mode a free-running toggle marks every
// second clock edge after reset release. Assumes a single clock domain and
// that the select may change at any time; the toggle phase is never reset
// by a select change.
module gdt_tick_gen
    import gdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    output logic tick
);

    logic half_q;

    // Free-running divide-by-two phase, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    // Select the tick enable for the current cycle
    always_comb begin
        if (src_sel == SRC_CLK_DIV2) begin
            tick = half_q;
        end else begin
            tick = 1'b1;
        end
    end

    // R5: in half-rate mode two consecutive ticks never occur
    p_half_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_CLK_DIV2 && tick) |=> !(src_sel == SRC_CLK_DIV2 && tick));

endmodule

// File: rtl/gdt_setting_reg.sv
// Module gdt_setting_reg
// Holds the dead-time tick count. It resets to 1 so that outputs are always
// delayed by at least one tick. The effective count maps a stored 0 to 1.
// Assumes the load strobe is synchronous to clk.
module gdt_setting_reg #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] count_n
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] set_q;

    // Capture a new setting on a load strobe; reset value is one tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= ONE;
        end else if (load) begin
            set_q <= din;
        end
    end

    // Replace the illegal zero count by the smallest legal one
    always_comb begin
        if (set_q == '0) begin
            count_n = ONE;
        end else begin
            count_n = set_q;
        end
    end

    // R2: a load strobe stores the presented value
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (set_q == $past(din)));

endmodule

// File: rtl/gdt_gate_channel.sv
// Module gdt_gate_channel
// Conditions one gate line. A switch-on request (raw high) is granted only
// after count_n ticks following a start event. A switch-off (raw low) is
// passed combinationally and clears any pending count. In bypass the grant
// flag tracks the raw line, so re-enabling keeps an already-on gate on.
// Assumes count_n is never zero and that tick is a one-cycle enable.
module gdt_gate_channel
    import gdt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dt_en,
    input  logic             trig_sel,
    input  logic             tick,
    input  logic             tmr_uflow,
    input  logic [CNT_W-1:0] count_n,
    input  logic             raw,
    output logic             gate
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             raw_q;
    logic             run_q;
    logic             act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_edge;
    logic             start_tmr;
    logic             start;

    // Remember the previous raw level for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else begin
            raw_q <= raw;
        end
    end

    // Derive the start event from the selected trigger source
    always_comb begin
        start_edge = raw & ~raw_q;
        start_tmr  = tmr_uflow & raw & ~act_q & ~run_q;
        if (trig_sel == TRIG_TIMER) begin
            start = start_tmr;
        end else begin
            start = start_edge;
        end
    end

    // Dead-time counter and switch-on grant flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (!dt_en) begin
            run_q <= 1'b0;
            act_q <= raw;
            cnt_q <= '0;
        end else if (!raw) begin
            run_q <= 1'b0;
            act_q <= 1'b0;
        end else if (start && !act_q) begin
            run_q <= 1'b1;
            cnt_q <= count_n;
        end else if (run_q && tick) begin
            if (cnt_q == ONE) begin
                run_q <= 1'b0;
                act_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // Switch-off passes at once; switch-on needs the grant unless bypassed
    always_comb begin
        if (dt_en) begin
            gate = raw & act_q;
        end else begin
            gate = raw;
        end
    end

    // R3: a grant appears only on the tick that ends a running count
    p_grant_after_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dt_en) && $rose(act_q)) |-> $past(run_q && tick && (cnt_q == ONE)));

    // R3: the output never conducts while its count is still running
    p_no_early_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_en && run_q) |-> !gate);

    // R2: a running count never holds zero
    p_run_count_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q != '0));

    // R8: a raw drop during a count cancels it and withholds the grant
    p_cancel_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_en && !raw && run_q) |=> (!run_q && !act_q));

endmodule

// File: rtl/gate_deadtime.sv
// Module gate_deadtime
// Top of the gate dead-time inserter. One shared tick generator and setting
// register feed N_GATES independent channel conditioners. Assumes all inputs
// are synchronous to clk and that tmr_uflow is a one-cycle pulse.
module gate_deadtime
    import gdt_pkg::*;
#(
    parameter int unsigned N_GATES = 6,
    parameter int unsigned CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   dt_setting,
    input  logic               dt_load,
    input  logic               src_half,
    input  logic               trig_timer,
    input  logic               dt_enable,
    input  logic               tmr_uflow,
    input  logic [N_GATES-1:0] gate_raw,
    output logic [N_GATES-1:0] gate_out
);

    logic             tick;
    logic [CNT_W-1:0] count_n;

    gdt_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_half),
        .tick    (tick)
    );

    gdt_setting_reg #(
        .CNT_W (CNT_W)
    ) u_setting (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dt_load),
        .din     (dt_setting),
        .count_n (count_n)
    );

    // One conditioner per gate line
    for (genvar g = 0; g < N_GATES; g++) begin : g_chan
        gdt_gate_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .dt_en     (dt_enable),
            .trig_sel  (trig_timer),
            .tick      (tick),
            .tmr_uflow (tmr_uflow),
            .count_n   (count_n),
            .raw       (gate_raw[g]),
            .gate      (gate_out[g])
        );
    end

    // R9: with the enable clear the outputs copy the raw gates on every edge
    p_bypass_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dt_enable && $past(!dt_enable)) |-> (gate_out == gate_raw));

endmodule

// File: tb/gate_deadtime_bench.sv
// Scoreboard bench: driver tasks push expected output words tagged with the
// cycle index; a monitor pops and compares them at each falling edge.
module gate_deadtime_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] dt_setting;
    logic       dt_load;
    logic       src_half;
    logic       trig_timer;
    logic       dt_enable;
    logic       tmr_uflow;
    logic [5:0] gate_raw;
    logic [5:0] gate_out;

    gate_deadtime u_gate_deadtime (
        .clk        (clk),
        .rst_n      (rst_n),
        .dt_setting (dt_setting),
        .dt_load    (dt_load),
        .src_half   (src_half),
        .trig_timer (trig_timer),
        .dt_enable  (dt_enable),
        .tmr_uflow  (tmr_uflow),
        .gate_raw   (gate_raw),
        .gate_out   (gate_out)
    );

    always #4 clk = ~clk;

    // ph counts clock edges since reset release: after edge E_j it equals j+1
    int ph;
    always @(posedge clk) begin
        if (!rst_n) ph <= 0;
        else        ph <= ph + 1;
    end

    typedef struct {
        int         p;
        logic [5:0] v;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         n_chk = 0;
    int         n_bad = 0;
    logic [5:0] exp_cur = '0;

    task automatic push(input int p, input logic [5:0] v, input string tag);
        item_t it;
        it.p = p; it.v = v; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].p <= ph) begin
            n_chk++;
            if (sb[0].p < ph) begin
                n_bad++;
                $display("FAIL %s: item for cycle %0d missed (now %0d), expected %b",
                         sb[0].tag, sb[0].p, ph, sb[0].v);
            end else if (gate_out !== sb[0].v) begin
                n_bad++;
                $display("FAIL %s: cycle %0d gate_out=%b expected %b",
                         sb[0].tag, ph, gate_out, sb[0].v);
            end
            void'(sb.pop_front());
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, got hang expected completion");
        finish_run();
    end

    task automatic step(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (sb.size() > 0) step(1);
    endtask

    task automatic load_setting(input int n);
        dt_setting = 8'(n);
        dt_load    = 1'b1;
        step(1);
        dt_load    = 1'b0;
    endtask

    // Raise one raw gate (edge start) and expect the output after n ticks
    task automatic rise(input int ch, input int n, input string tag);
        int s;
        int d;
        s = ph;
        gate_raw[ch] = 1'b1;
        if (src_half) begin
            d = (s % 2 == 0) ? s + 1 : s + 2;
            d = d + 2 * (n - 1);
        end else begin
            d = s + n;
        end
        push(d, exp_cur, tag);
        exp_cur[ch] = 1'b1;
        push(d + 1, exp_cur, tag);
        drain();
    endtask

    // Drop one raw gate and expect the output low on the next sample
    task automatic fall(input int ch, input string tag);
        gate_raw[ch] = 1'b0;
        exp_cur[ch]  = 1'b0;
        push(ph + 1, exp_cur, tag);
        drain();
    endtask

    initial begin
        int p0;
        int p1;
        rst_n      = 1'b0;
        dt_setting = 8'd0;
        dt_load    = 1'b0;
        src_half   = 1'b0;
        trig_timer = 1'b0;
        dt_enable  = 1'b1;
        tmr_uflow  = 1'b0;
        gate_raw   = '0;
        step(3);
        rst_n = 1'b1;

        // R1: reset state, then default one-tick delay before any load
        push(ph + 1, 6'b000000, "R1 reset outputs low");
        drain();
        rise(0, 1, "R1 default setting one tick");
        // R4: switch-off is immediate
        fall(0, "R4 immediate switch-off");

        // R3/R6: full-rate, edge-started delay of 5
        load_setting(5);
        rise(2, 5, "R3 R6 delay of five ticks");
        fall(2, "R4 switch-off after delay");

        // R2: stored zero behaves as one; maximum 255
        load_setting(0);
        rise(1, 1, "R2 zero acts as one");
        fall(1, "R4");
        load_setting(255);
        rise(3, 255, "R2 maximum setting");
        fall(3, "R4");

        // R5: half-rate ticks, started on both clock parities
        src_half = 1'b1;
        load_setting(3);
        rise(4, 3, "R5 half rate first parity");
        fall(4, "R4");
        step(1);
        rise(5, 3, "R5 half rate other parity");
        fall(5, "R4");
        src_half = 1'b0;

        // R10: pair swap gives a gap of n ticks
        load_setting(4);
        rise(0, 4, "R10 pair setup");
        p0 = ph;
        gate_raw[0] = 1'b0;
        gate_raw[1] = 1'b1;
        exp_cur[0]  = 1'b0;
        push(p0 + 1, exp_cur, "R10 outgoing drops at once");
        push(p0 + 4, exp_cur, "R10 incoming still held");
        exp_cur[1] = 1'b1;
        push(p0 + 5, exp_cur, "R10 incoming after dead time");
        drain();
        fall(1, "R4");

        // R8: a drop during the count cancels it
        load_setting(10);
        p0 = ph;
        gate_raw[2] = 1'b1;
        step(4);
        gate_raw[2] = 1'b0;
        step(2);
        p1 = ph;
        gate_raw[2] = 1'b1;
        push(p0 + 11, exp_cur, "R8 stale count must not grant");
        push(p1 + 10, exp_cur, "R8 new count still running");
        exp_cur[2] = 1'b1;
        push(p1 + 11, exp_cur, "R8 grant after full new count");
        drain();
        fall(2, "R4");

        // R7: timer start; raw rise alone does nothing
        trig_timer = 1'b1;
        load_setting(3);
        p0 = ph;
        gate_raw[4] = 1'b1;
        push(p0 + 8, exp_cur, "R7 raw rise ignored in timer mode");
        drain();
        p1 = ph;
        tmr_uflow = 1'b1;
        step(1);
        tmr_uflow = 1'b0;
        push(p1 + 3, exp_cur, "R7 count running after pulse");
        exp_cur[4] = 1'b1;
        push(p1 + 4, exp_cur, "R7 grant after pulse and count");
        drain();
        fall(4, "R4");
        trig_timer = 1'b0;

        // R9: bypass copies raw, re-enable keeps an on gate on
        load_setting(200);
        dt_enable = 1'b0;
        step(1);
        gate_raw[5] = 1'b1;
        exp_cur[5]  = 1'b1;
        push(ph + 1, exp_cur, "R9 bypass follows raw");
        drain();
        fall(5, "R9 bypass follows drop");
        gate_raw[5] = 1'b1;
        exp_cur[5]  = 1'b1;
        push(ph + 1, exp_cur, "R9 bypass follows raw again");
        drain();
        p0 = ph;
        dt_enable = 1'b1;
        push(p0 + 1, exp_cur, "R9 re-enable keeps output on");
        push(p0 + 3, exp_cur, "R9 re-enable no new delay");
        drain();
        fall(5, "R4");

        step(2);
        finish_run();
    end

endmodule